// File: doc/BRIEF.md
# Prescaled Countdown Interval Timer

This block is a 16-bit interval timer that counts down once per prescale period, a programmable number of system clock cycles. When a decrement would bring the count to zero, the counter reloads from a programmable reload register instead. In the same cycle it latches a sticky zero-status flag in the control byte and, if interrupts are enabled, raises a one-cycle interrupt request tagged with a fixed priority level.

Software reaches the timer through a byte-wide register port. A write strobe, a 3-bit byte address and a write byte form the write side. The read byte is a combinational function of the address. The control byte holds the run bit, the sticky zero flag and the interrupt-enable bit. The live count is read as separate low and high bytes. The reload value and the prescale period are each written as two bytes. The port has no valid/ready handshake: a write is accepted on every clock edge where the strobe is high.

Top module: `ivt_top`

## Requirements
- R1: During and right after reset, address 0 (control) reads 0xE4, addresses 1 and 2 (count low/high) read 0xFF, addresses 3 and 4 (reload low/high) read 0xFF, addresses 5 and 6 (period low/high) read 0xD0 and 0x07 (2000), address 7 reads 0x00, and irq_req is low.
- R2: While control bit 0 is 0, neither the count nor the prescale phase advances. Re-enabling resumes from the phase that was frozen.
- R3: With period value N in addresses 5 (low byte) and 6 (high byte), a running timer decrements on every Nth enabled clock edge. N of 0 or 1 means every edge.
- R4: Addresses 1 and 2 show the low and high bytes of the count, updated on the edge of every decrement. Writes to addresses 1, 2 and 7 change nothing.
- R5: On a decrement step where the count is 1 or 0, the count loads the reload value instead, and control bit 1 is set on that edge. The count never wraps below zero.
- R6: When control bit 3 is 1 at a reload step, irq_req is high for the cycle in which the reloaded count is visible. Otherwise irq_req stays low. irq_level always reads 1.
- R7: A control write with bit 1 as 1 clears the zero flag. A write with bit 1 as 0 leaves it unchanged. If a reload step coincides with a clearing write, the flag ends up set.
- R8: Control bits 0 and 2 to 7 read back the last value written to address 0.
- R9: Writes to addresses 3 and 4 (reload) and 5 and 6 (period) replace only the addressed byte. A new reload value takes effect at the next reload step, and a new period takes effect at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Byte write strobe, sampled on the rising edge |
| reg_addr | input | 3 | Byte address for read and write |
| reg_wdata | input | 8 | Write byte |
| reg_rdata | output | 8 | Read byte for reg_addr (combinational) |
| irq_req | output | 1 | Interrupt request, one cycle per reload step with interrupts enabled |
| irq_level | output | 4 | Fixed priority level of the request (1) |

## Verification
The assertions assume that every input is synchronous to clk and stable around the rising edge. They also assume that reset is asserted before the first checked edge, so the stored reload value is known when the count changes. The bench changes inputs only on the falling edge and holds reset for several cycles at the start. During the random phase it keeps the period and reload values small so that reloads, flag clears and back-to-back requests happen often. One long run with a period of one cycle carries the count all the way down from its reset value of 0xFFFF.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int unsigned IVT_BYTE_W = 8;
  localparam int unsigned IVT_AW     = 3;

  typedef enum logic [IVT_AW-1:0] {
    A_CTRL   = 3'd0,
    A_CNT_LO = 3'd1,
    A_CNT_HI = 3'd2,
    A_RLD_LO = 3'd3,
    A_RLD_HI = 3'd4,
    A_PER_LO = 3'd5,
    A_PER_HI = 3'd6,
    A_SPARE  = 3'd7
  } ivt_addr_e;

  localparam int unsigned CB_RUN   = 0;
  localparam int unsigned CB_ZERO  = 1;
  localparam int unsigned CB_IRQEN = 3;
endpackage

// File: rtl/ivt_prescaler.sv
module ivt_prescaler #(
  parameter int unsigned PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PER_W-1:0] period,
  output logic             tick
);
  logic [PER_W-1:0] phase_q;
  logic [PER_W:0]   phase_next;

  assign phase_next = {1'b0, phase_q} + (PER_W+1)'(1);
  // period 0 and 1 both tick on every enabled edge
  assign tick = run && (phase_next >= {1'b0, period});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (run) begin
      if (tick) phase_q <= '0;
      else      phase_q <= phase_next[PER_W-1:0];
    end
  end
endmodule

// File: rtl/ivt_counter.sv
module ivt_counter #(
  parameter int unsigned CNT_W   = 16,
  parameter logic [CNT_W-1:0] CNT_RST = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             zero_hit
);
  logic [CNT_W-1:0] count_q;

  // a step from 1 or from 0 would land on zero: reload instead
  assign zero_hit = tick && (count_q <= CNT_W'(1));
  assign count    = count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= CNT_RST;
    end else if (tick) begin
      if (zero_hit) count_q <= reload;
      else          count_q <= count_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/ivt_regs.sv
module ivt_regs
  import ivt_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PER_W = 16,
  parameter logic [IVT_BYTE_W-1:0] CTRL_RST = 8'hE4,
  parameter logic [CNT_W-1:0] RLD_RST = '1,
  parameter logic [PER_W-1:0] PER_RST = PER_W'(2000)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr,
  input  logic [IVT_AW-1:0]     addr,
  input  logic [IVT_BYTE_W-1:0] wdata,
  input  logic                  zero_hit,
  input  logic [CNT_W-1:0]      count,
  output logic [IVT_BYTE_W-1:0] ctrl,
  output logic [CNT_W-1:0]      reload,
  output logic [PER_W-1:0]      period,
  output logic [IVT_BYTE_W-1:0] rdata
);
  localparam int unsigned RLD_BYTES = CNT_W / IVT_BYTE_W;
  localparam int unsigned PER_BYTES = PER_W / IVT_BYTE_W;

  logic [IVT_BYTE_W-1:0] ctrl_q, ctrl_d;
  logic [CNT_W-1:0]      reload_q;
  logic [PER_W-1:0]      period_q;
  logic                  ctrl_wr;

  assign ctrl_wr = wr && (ivt_addr_e'(addr) == A_CTRL);

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr) begin
      ctrl_d          = wdata;
      ctrl_d[CB_ZERO] = ctrl_q[CB_ZERO] & ~wdata[CB_ZERO];
    end
    // hardware set wins over a simultaneous software clear
    if (zero_hit) ctrl_d[CB_ZERO] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= CTRL_RST;
    else        ctrl_q <= ctrl_d;
  end

  for (genvar b = 0; b < RLD_BYTES; b++) begin : g_rld
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        reload_q[b*IVT_BYTE_W +: IVT_BYTE_W] <= RLD_RST[b*IVT_BYTE_W +: IVT_BYTE_W];
      else if (wr && (addr == IVT_AW'(A_RLD_LO) + IVT_AW'(b)))
        reload_q[b*IVT_BYTE_W +: IVT_BYTE_W] <= wdata;
    end
  end

  for (genvar b = 0; b < PER_BYTES; b++) begin : g_per
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        period_q[b*IVT_BYTE_W +: IVT_BYTE_W] <= PER_RST[b*IVT_BYTE_W +: IVT_BYTE_W];
      else if (wr && (addr == IVT_AW'(A_PER_LO) + IVT_AW'(b)))
        period_q[b*IVT_BYTE_W +: IVT_BYTE_W] <= wdata;
    end
  end

  always_comb begin
    unique case (ivt_addr_e'(addr))
      A_CTRL:   rdata = ctrl_q;
      A_CNT_LO: rdata = count[7:0];
      A_CNT_HI: rdata = count[15:8];
      A_RLD_LO: rdata = reload_q[7:0];
      A_RLD_HI: rdata = reload_q[15:8];
      A_PER_LO: rdata = period_q[7:0];
      A_PER_HI: rdata = period_q[15:8];
      default:  rdata = '0;
    endcase
  end

  assign ctrl   = ctrl_q;
  assign reload = reload_q;
  assign period = period_q;
endmodule

// File: rtl/ivt_top.sv
module ivt_top
  import ivt_pkg::*;
#(
  parameter int unsigned IRQ_LVL_W = 4,
  parameter int unsigned IRQ_LEVEL = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic [IVT_AW-1:0]     reg_addr,
  input  logic [IVT_BYTE_W-1:0] reg_wdata,
  output logic [IVT_BYTE_W-1:0] reg_rdata,
  output logic                  irq_req,
  output logic [IRQ_LVL_W-1:0]  irq_level
);
  localparam int unsigned CNT_W = 2 * IVT_BYTE_W;
  localparam int unsigned PER_W = 2 * IVT_BYTE_W;

  logic [IVT_BYTE_W-1:0] ctrl_q;
  logic [CNT_W-1:0]      reload_q;
  logic [CNT_W-1:0]      count_q;
  logic [PER_W-1:0]      period_q;
  logic                  tick;
  logic                  zero_hit;
  logic                  irq_q;

  ivt_prescaler #(.PER_W(PER_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (ctrl_q[CB_RUN]),
    .period (period_q),
    .tick   (tick)
  );

  ivt_counter #(.CNT_W(CNT_W), .CNT_RST('1)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .reload   (reload_q),
    .count    (count_q),
    .zero_hit (zero_hit)
  );

  ivt_regs #(
    .CNT_W    (CNT_W),
    .PER_W    (PER_W),
    .CTRL_RST (8'hE4),
    .RLD_RST  ('1),
    .PER_RST  (PER_W'(2000))
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .zero_hit (zero_hit),
    .count    (count_q),
    .ctrl     (ctrl_q),
    .reload   (reload_q),
    .period   (period_q),
    .rdata    (reg_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= zero_hit && ctrl_q[CB_IRQEN];
  end

  assign irq_req   = irq_q;
  assign irq_level = IRQ_LVL_W'(IRQ_LEVEL);
endmodule

// File: rtl/ivt_chk.sv
module ivt_chk
  import ivt_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  reg_wr,
  input logic [IVT_AW-1:0]     reg_addr,
  input logic [IVT_BYTE_W-1:0] reg_wdata,
  input logic                  irq_req,
  input logic [IVT_BYTE_W-1:0] ctrl,
  input logic [15:0]           count,
  input logic [15:0]           reload
);
  // R2
  frozen_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[CB_RUN] |=> $stable(count));

  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(count) |-> ((count == $past(count) - 16'd1) || (count == $past(reload))));

  // R5
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(count) == 16'd0 && !$stable(count)) |-> (count == $past(reload)));

  // R6
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ctrl[CB_ZERO]);

  // R6
  irq_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> $past(ctrl[CB_IRQEN]));

  // R7
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[CB_ZERO] && !(reg_wr && reg_addr == IVT_AW'(A_CTRL) && reg_wdata[CB_ZERO]))
      |=> ctrl[CB_ZERO]);
endmodule

bind ivt_top ivt_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .irq_req   (irq_req),
  .ctrl      (ctrl_q),
  .count     (count_q),
  .reload    (reload_q)
);

// File: tb/test_ivt_top.sv
module test_ivt_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq_req;
  logic [3:0] irq_level;

  int checks = 0;
  int errors = 0;
  int sweep = 0;

  int m_ctrl, m_cnt, m_rld, m_per, m_pre;
  bit m_irq;

  always #5 clk = ~clk;

  ivt_top i_ivt_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_req   (irq_req),
    .irq_level (irq_level)
  );

  // behavioural reference, stepped on each rising edge
  always @(posedge clk) begin
    bit en, tick, zh;
    int nc;
    if (!rst_n) begin
      m_ctrl = 'hE4; m_cnt = 'hFFFF; m_rld = 'hFFFF; m_per = 2000; m_pre = 0; m_irq = 0;
    end else begin
      en   = (m_ctrl & 1) != 0;
      tick = en && (m_pre + 1 >= m_per);
      zh   = tick && (m_cnt <= 1);
      nc   = m_ctrl;
      if (reg_wr && reg_addr == 0)
        nc = (int'(reg_wdata) & 'hFD) | ((m_ctrl & 2) & ~(int'(reg_wdata) & 2));
      if (zh) nc = nc | 2;
      m_irq = zh && ((m_ctrl & 8) != 0);
      if (en) m_pre = tick ? 0 : m_pre + 1;
      if (tick) m_cnt = zh ? m_rld : m_cnt - 1;
      if (reg_wr) begin
        case (reg_addr)
          3: m_rld = (m_rld & 'hFF00) | int'(reg_wdata);
          4: m_rld = (m_rld & 'h00FF) | (int'(reg_wdata) << 8);
          5: m_per = (m_per & 'hFF00) | int'(reg_wdata);
          6: m_per = (m_per & 'h00FF) | (int'(reg_wdata) << 8);
          default: ;
        endcase
      end
      m_ctrl = nc;
    end
  end

  function automatic int exp_rd(input int a);
    case (a)
      0: return m_ctrl;
      1: return m_cnt & 'hFF;
      2: return (m_cnt >> 8) & 'hFF;
      3: return m_rld & 'hFF;
      4: return (m_rld >> 8) & 'hFF;
      5: return m_per & 'hFF;
      6: return (m_per >> 8) & 'hFF;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(input int a);
    if (!rst_n) return "R1";
    case (a)
      0: return ((m_ctrl & 1) == 0) ? "R2" : "R7/R8";
      1, 2: return ((m_ctrl & 1) == 0) ? "R2" : "R4/R5";
      3, 4: return "R9";
      5, 6: return "R3";
      default: return "R4";
    endcase
  endfunction

  // compare every cycle, a little after the rising edge
  always begin
    @(posedge clk);
    #3;
    checks++;
    if (int'(reg_rdata) != exp_rd(int'(reg_addr))) begin
      errors++;
      $display("FAIL %s addr=%0d actual=%02h expected=%02h",
               tag_of(int'(reg_addr)), reg_addr, reg_rdata, exp_rd(int'(reg_addr)));
    end
    checks++;
    if (irq_req !== m_irq) begin
      errors++;
      $display("FAIL R6 irq_req actual=%0b expected=%0b", irq_req, m_irq);
    end
    checks++;
    if (irq_level !== 4'd1) begin
      errors++;
      $display("FAIL R6 irq_level actual=%0d expected=1", irq_level);
    end
  end

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      reg_wr   = 1'b0;
      reg_addr = 3'(sweep);
      sweep++;
    end
  endtask

  task automatic put(input int a, input int d);
    @(negedge clk);
    reg_wr    = 1'b1;
    reg_addr  = 3'(a);
    reg_wdata = 8'(d);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset values swept over every address while reset is held
    idle(8);
    @(negedge clk) rst_n = 1'b1;
    idle(8);
    // R5: long run at one-cycle period from 0xFFFF, reload 5, interrupts on
    put(3, 5); put(4, 0); put(5, 1); put(6, 0); put(0, 'h09);
    idle(65545);
    // R3: period 3
    put(5, 3);
    idle(60);
    // R2: freeze mid-period and resume
    put(0, 'h08);
    idle(12);
    put(0, 'h09);
    idle(30);
    // R4: writes to count bytes and the spare address are ignored
    put(1, 'h12); put(2, 'h34); put(7, 'h56);
    idle(10);
    // R7: write 0 keeps the flag, write 1 clears it
    put(0, 'h09); idle(2);
    put(0, 'h0B); idle(2);
    // R5 and R6: reload 0 and 1 at period 0 give a request on every edge
    put(3, 0); put(5, 0); idle(12);
    put(0, 'h0B); put(0, 'h0B); idle(4);
    put(3, 1); idle(12);
    // R6: interrupts disabled
    put(0, 'h03); idle(20);
    // R8: upper control bits read back
    put(0, 'hF5); idle(16);
    put(0, 'h0C); idle(8);
    // R9: new reload value used at the next reload only
    put(5, 4); put(3, 9); put(0, 'h09); idle(80);
    // random phase, small period and reload values
    for (int i = 0; i < 3000; i++) begin
      int a, d;
      a = int'($urandom_range(0, 7));
      d = int'($urandom_range(0, 255));
      if (a == 6 || a == 4) d = 0;
      if (a == 5) d = d & 7;
      if (a == 3) d = d & 15;
      if ($urandom_range(0, 3) == 0) put(a, d);
      else idle(1);
    end
    idle(4);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule